// File: doc/BRIEF.md
# Bus Transfer Interrupt and DMA Request Logic

This block keeps the first interrupt status register of a parallel instrument-bus talker/listener. It raises six sticky flags from interface-state inputs: byte-out, byte-in, bus error, end of message, trigger received and device clear. The CPU clears these flags through its register strobes. An interrupt line is driven from the flags through a CPU-written enable register. A separate DMA request line follows byte-in and byte-out under two enable bits. A trigger pin pulses when a trigger command arrives while the device is listening.

The DMA request line is used by a transfer engine, or as a second interrupt line. It is not cleared by a status read. Only a data-register access clears it, so the engine never loses a pending transfer when software polls the status. End of message is reported when the end line is asserted with a byte, or when the received byte matches a programmable end-of-string character.

Top module: `xfer_irq_unit`

## Requirements
- R1: After reset, all six status flags, the enable register, `dreq`, `irq` and `trig` are 0.
- R2: Byte-out (`stat[1]`) sets in the cycle after `tal_active & src_ready` changes from false to true. Holding the condition does not set it again.
- R3: Byte-out clears on a CPU data-out write, on `atn` high, or in the cycle after `talk_addressed` falls.
- R4: Byte-in (`stat[0]`) sets on `byte_accepted` and clears on a CPU data-in read.
- R5: A CPU status read clears all six flags. `pon` clears only byte-in and byte-out.
- R6: The error flag (`stat[2]`) sets when `no_byte_avail`, `tal_active`, `dac_line` and `rfd_line` are all high.
- R7: The end flag (`stat[3]`) sets on `byte_accepted` only while `lis_active` is high, and only when `eoi` is high or `rx_byte` equals `eos_char`.
- R8: The trigger flag (`stat[4]`) sets on `get_cmd` while `listen_addressed` is high. The same event drives `trig` high for exactly the next cycle.
- R9: The device-clear flag (`stat[5]`) sets in the cycle after `dcas_active` rises.
- R10: An enable write takes `cpu_wdata`. Bits 5..0 are per-flag interrupt enables, bit 6 enables DMA-in and bit 7 enables DMA-out. `irq` is high exactly when some flag and its enable are both 1.
- R11: `dreq` sets on a byte-in event while DMA-in is enabled, and on a byte-out event while DMA-out is enabled. It clears only on a data-out write or a data-in read. A status read and `pon` leave it unchanged.
- R12: If a set event and any clear of the same flag, or of `dreq`, happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pon | input | 1 | Power-on local message, clears byte flags |
| tal_active | input | 1 | Talker in its active state |
| src_ready | input | 1 | Source handshake in its wait-new-cycle or generate state |
| talk_addressed | input | 1 | Device addressed to talk |
| atn | input | 1 | Attention line level |
| no_byte_avail | input | 1 | No new byte is available to send |
| dac_line | input | 1 | Data-accepted line asserted |
| rfd_line | input | 1 | Ready-for-data line asserted |
| lis_active | input | 1 | Listener in its active state |
| listen_addressed | input | 1 | Device addressed to listen |
| byte_accepted | input | 1 | Input byte accepted this cycle |
| eoi | input | 1 | End line level with the byte |
| rx_byte | input | DATA_W | Received data byte |
| eos_char | input | DATA_W | Programmed end-of-string character |
| get_cmd | input | 1 | Trigger command received this cycle |
| dcas_active | input | 1 | Device-clear active state |
| cpu_rd_din | input | 1 | CPU reads the data-in register |
| cpu_wr_dout | input | 1 | CPU writes the data-out register |
| cpu_rd_stat | input | 1 | CPU reads the status register |
| cpu_wr_ien | input | 1 | CPU writes the enable register |
| cpu_wdata | input | 8 | Enable register write data |
| stat | output | 6 | Status flags |
| irq | output | 1 | Interrupt request |
| dreq | output | 1 | DMA request |
| trig | output | 1 | Trigger pulse |

## Verification
The bench targets the split between the status read and the DMA line. A design that lets a status read clear `dreq` would drop the line while a byte is still pending. It also fires set and clear in the same cycle, which shows a design that loses an event because it gives the read priority. Byte-out is held with its condition true across cycles, so a design that sets on the level would bring the flag back right after a data-out write. The end flag is driven with a matching byte and with `eoi` while not listening, to catch a comparator that is not qualified by the listener state.

// File: rtl/xfer_irq_pkg.sv
package xfer_irq_pkg;
  localparam int NFLAG       = 6;
  localparam int F_BI        = 0;
  localparam int F_BO        = 1;
  localparam int F_ERR       = 2;
  localparam int F_END       = 3;
  localparam int F_GET       = 4;
  localparam int F_DEC       = 5;
  localparam int IEN_W       = NFLAG + 2;
  localparam int DMA_IN_BIT  = NFLAG;
  localparam int DMA_OUT_BIT = NFLAG + 1;

  // Sticky bit update: a set in the same cycle as a clear is kept (R12).
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/xfer_flag_cell.sv
module xfer_flag_cell
  import xfer_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/xfer_event_decode.sv
module xfer_event_decode
  import xfer_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pon,
  input  logic              tal_active,
  input  logic              src_ready,
  input  logic              talk_addressed,
  input  logic              atn,
  input  logic              no_byte_avail,
  input  logic              dac_line,
  input  logic              rfd_line,
  input  logic              lis_active,
  input  logic              listen_addressed,
  input  logic              byte_accepted,
  input  logic              eoi,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] eos_char,
  input  logic              get_cmd,
  input  logic              dcas_active,
  input  logic              cpu_rd_din,
  input  logic              cpu_wr_dout,
  input  logic              cpu_rd_stat,
  output logic [NFLAG-1:0]  set_vec,
  output logic [NFLAG-1:0]  clr_vec
);
  function automatic logic end_hit(logic eoi_i, logic [DATA_W-1:0] rx,
                                   logic [DATA_W-1:0] eos);
    return eoi_i | (rx == eos);
  endfunction

  logic bo_cond, bo_cond_q, talk_q, dcas_q;
  logic ev_bo_set, ev_bi_set, ev_err_set, ev_end_set, ev_get_set, ev_dec_set;
  logic ev_talk_lost;

  assign bo_cond = tal_active & src_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_cond_q <= 1'b0;
      talk_q    <= 1'b0;
      dcas_q    <= 1'b0;
    end else begin
      bo_cond_q <= bo_cond;
      talk_q    <= talk_addressed;
      dcas_q    <= dcas_active;
    end
  end

  assign ev_bo_set    = bo_cond & ~bo_cond_q;
  assign ev_talk_lost = talk_q & ~talk_addressed;
  assign ev_bi_set    = byte_accepted;
  assign ev_err_set   = no_byte_avail & tal_active & dac_line & rfd_line;
  assign ev_end_set   = lis_active & byte_accepted & end_hit(eoi, rx_byte, eos_char);
  assign ev_get_set   = get_cmd & listen_addressed;
  assign ev_dec_set   = dcas_active & ~dcas_q;

  always_comb begin
    set_vec        = '0;
    set_vec[F_BI]  = ev_bi_set;
    set_vec[F_BO]  = ev_bo_set;
    set_vec[F_ERR] = ev_err_set;
    set_vec[F_END] = ev_end_set;
    set_vec[F_GET] = ev_get_set;
    set_vec[F_DEC] = ev_dec_set;

    clr_vec        = {NFLAG{cpu_rd_stat}};
    clr_vec[F_BI]  = cpu_rd_stat | pon | cpu_rd_din;
    clr_vec[F_BO]  = cpu_rd_stat | pon | cpu_wr_dout | atn | ev_talk_lost;
  end
endmodule

// File: rtl/xfer_dreq_gen.sv
module xfer_dreq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic bi_ev,
  input  logic bo_ev,
  input  logic dma_in_en,
  input  logic dma_out_en,
  input  logic cpu_rd_din,
  input  logic cpu_wr_dout,
  output logic dreq
);
  logic req_set, req_clr;

  assign req_set = (bi_ev & dma_in_en) | (bo_ev & dma_out_en);
  assign req_clr = cpu_rd_din | cpu_wr_dout;

  xfer_flag_cell u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req_set),
    .clr_i (req_clr),
    .q_o   (dreq)
  );
endmodule

// File: rtl/xfer_irq_unit.sv
module xfer_irq_unit
  import xfer_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pon,
  input  logic              tal_active,
  input  logic              src_ready,
  input  logic              talk_addressed,
  input  logic              atn,
  input  logic              no_byte_avail,
  input  logic              dac_line,
  input  logic              rfd_line,
  input  logic              lis_active,
  input  logic              listen_addressed,
  input  logic              byte_accepted,
  input  logic              eoi,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] eos_char,
  input  logic              get_cmd,
  input  logic              dcas_active,
  input  logic              cpu_rd_din,
  input  logic              cpu_wr_dout,
  input  logic              cpu_rd_stat,
  input  logic              cpu_wr_ien,
  input  logic [IEN_W-1:0]  cpu_wdata,
  output logic [NFLAG-1:0]  stat,
  output logic              irq,
  output logic              dreq,
  output logic              trig
);
  logic [NFLAG-1:0] flag_set, flag_clr, stat_q;
  logic [IEN_W-1:0] ien_q;
  logic             trig_q;

  xfer_event_decode #(.DATA_W(DATA_W)) u_dec (
    .clk              (clk),
    .rst_n            (rst_n),
    .pon              (pon),
    .tal_active       (tal_active),
    .src_ready        (src_ready),
    .talk_addressed   (talk_addressed),
    .atn              (atn),
    .no_byte_avail    (no_byte_avail),
    .dac_line         (dac_line),
    .rfd_line         (rfd_line),
    .lis_active       (lis_active),
    .listen_addressed (listen_addressed),
    .byte_accepted    (byte_accepted),
    .eoi              (eoi),
    .rx_byte          (rx_byte),
    .eos_char         (eos_char),
    .get_cmd          (get_cmd),
    .dcas_active      (dcas_active),
    .cpu_rd_din       (cpu_rd_din),
    .cpu_wr_dout      (cpu_wr_dout),
    .cpu_rd_stat      (cpu_rd_stat),
    .set_vec          (flag_set),
    .clr_vec          (flag_clr)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    xfer_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .q_o   (stat_q[i])
    );
  end

  xfer_dreq_gen u_dreq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bi_ev       (flag_set[F_BI]),
    .bo_ev       (flag_set[F_BO]),
    .dma_in_en   (ien_q[DMA_IN_BIT]),
    .dma_out_en  (ien_q[DMA_OUT_BIT]),
    .cpu_rd_din  (cpu_rd_din),
    .cpu_wr_dout (cpu_wr_dout),
    .dreq        (dreq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      if (cpu_wr_ien) ien_q <= cpu_wdata;
      trig_q <= flag_set[F_GET];
    end
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & ien_q[NFLAG-1:0]);
  assign trig = trig_q;
endmodule

// File: rtl/xfer_irq_unit_chk.sv
module xfer_irq_unit_chk
  import xfer_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             atn,
  input logic             tal_active,
  input logic             no_byte_avail,
  input logic             dac_line,
  input logic             rfd_line,
  input logic             lis_active,
  input logic             listen_addressed,
  input logic             get_cmd,
  input logic             cpu_rd_stat,
  input logic             cpu_rd_din,
  input logic             cpu_wr_dout,
  input logic [NFLAG-1:0] flag_set,
  input logic [NFLAG-1:0] stat,
  input logic             dreq,
  input logic             trig
);
  p_bo_drop_on_atn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (atn && !flag_set[F_BO]) |=> !stat[F_BO]);

  p_stat_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_stat && flag_set == '0) |=> stat == '0);

  p_err_no_listener_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tal_active && no_byte_avail && dac_line && rfd_line) |=> stat[F_ERR]);

  p_end_needs_listener_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[F_END]) |-> $past(lis_active));

  p_trig_from_get_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(get_cmd && listen_addressed));

  p_dreq_survives_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && cpu_rd_stat && !cpu_rd_din && !cpu_wr_dout) |=> dreq);

  p_set_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[F_BI] |=> stat[F_BI]);
endmodule

bind xfer_irq_unit xfer_irq_unit_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .atn              (atn),
  .tal_active       (tal_active),
  .no_byte_avail    (no_byte_avail),
  .dac_line         (dac_line),
  .rfd_line         (rfd_line),
  .lis_active       (lis_active),
  .listen_addressed (listen_addressed),
  .get_cmd          (get_cmd),
  .cpu_rd_stat      (cpu_rd_stat),
  .cpu_rd_din       (cpu_rd_din),
  .cpu_wr_dout      (cpu_wr_dout),
  .flag_set         (flag_set),
  .stat             (stat),
  .dreq             (dreq),
  .trig             (trig)
);

// File: tb/xfer_irq_unit_test.sv
module xfer_irq_unit_test;
  localparam logic [15:0] C_TAL  = 16'h0001;
  localparam logic [15:0] C_SRC  = 16'h0002;
  localparam logic [15:0] C_TADR = 16'h0004;
  localparam logic [15:0] C_ATN  = 16'h0008;
  localparam logic [15:0] C_BACC = 16'h0010;
  localparam logic [15:0] C_LIS  = 16'h0020;
  localparam logic [15:0] C_EOI  = 16'h0040;
  localparam logic [15:0] C_NBA  = 16'h0080;
  localparam logic [15:0] C_DAC  = 16'h0100;
  localparam logic [15:0] C_RFD  = 16'h0200;
  localparam logic [15:0] C_GET  = 16'h0400;
  localparam logic [15:0] C_LADR = 16'h0800;
  localparam logic [15:0] C_DCAS = 16'h1000;
  localparam logic [15:0] C_RDIN = 16'h2000;
  localparam logic [15:0] C_WOUT = 16'h4000;
  localparam logic [15:0] C_RST  = 16'h8000;
  localparam logic [15:0] C_NONE = 16'h0000;
  localparam logic [7:0]  EOS    = 8'h0A;

  // {ctrl, rx, expected stat[5:0] = DEC GET END ERR BO BI, irq, dreq, trig}
  localparam int NV = 28;
  localparam logic [32:0] VEC [NV] = '{
    {C_NONE,               8'h00, 6'b000000, 1'b0, 1'b0, 1'b0},
    {C_TAL|C_SRC|C_TADR,   8'h00, 6'b000010, 1'b1, 1'b1, 1'b0}, // R2 R11
    {C_TAL|C_SRC|C_TADR,   8'h00, 6'b000010, 1'b1, 1'b1, 1'b0}, // R2 level hold
    {C_TAL|C_TADR|C_WOUT,  8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}, // R3 write
    {C_TAL|C_SRC|C_TADR,   8'h00, 6'b000010, 1'b1, 1'b1, 1'b0},
    {C_TADR|C_ATN,         8'h00, 6'b000000, 1'b0, 1'b1, 1'b0}, // R3 atn
    {C_TAL|C_SRC|C_TADR,   8'h00, 6'b000010, 1'b1, 1'b1, 1'b0},
    {C_NONE,               8'h00, 6'b000000, 1'b0, 1'b1, 1'b0}, // R3 untalk
    {C_RDIN,               8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}, // R11
    {C_LIS|C_LADR|C_BACC,  8'h41, 6'b000001, 1'b1, 1'b1, 1'b0}, // R4
    {C_LIS|C_LADR|C_RST,   8'h41, 6'b000000, 1'b0, 1'b1, 1'b0}, // R5 R11
    {C_LIS|C_LADR|C_RDIN,  8'h41, 6'b000000, 1'b0, 1'b0, 1'b0},
    {C_LIS|C_LADR|C_BACC,  8'h0A, 6'b001001, 1'b1, 1'b1, 1'b0}, // R7 eos
    {C_LIS|C_LADR|C_RDIN,  8'h0A, 6'b001000, 1'b1, 1'b0, 1'b0}, // R4 clear
    {C_LIS|C_LADR|C_BACC|C_EOI, 8'h33, 6'b001001, 1'b1, 1'b1, 1'b0}, // R7 eoi
    {C_LADR|C_RST|C_RDIN,  8'h33, 6'b000000, 1'b0, 1'b0, 1'b0},
    {C_BACC|C_EOI,         8'h0A, 6'b000001, 1'b1, 1'b1, 1'b0}, // R7 no listen
    {C_LADR|C_GET,         8'h00, 6'b010001, 1'b1, 1'b1, 1'b1}, // R8
    {C_GET|C_RST|C_RDIN,   8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}, // R8 unaddressed
    {C_TAL|C_NBA|C_DAC|C_RFD, 8'h00, 6'b000100, 1'b1, 1'b0, 1'b0}, // R6
    {C_TAL|C_NBA|C_DAC|C_RFD|C_RST, 8'h00, 6'b000100, 1'b1, 1'b0, 1'b0}, // R12
    {C_RST,                8'h00, 6'b000000, 1'b0, 1'b0, 1'b0},
    {C_TAL|C_NBA|C_DAC,    8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}, // R6 partial
    {C_DCAS,               8'h00, 6'b100000, 1'b1, 1'b0, 1'b0}, // R9
    {C_DCAS|C_RST,         8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}, // R9 no re-set
    {C_BACC|C_RST,         8'h00, 6'b000001, 1'b1, 1'b1, 1'b0}, // R12
    {C_BACC|C_RDIN,        8'h00, 6'b000001, 1'b1, 1'b1, 1'b0}, // R12 dreq too
    {C_RDIN|C_RST,         8'h00, 6'b000000, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, pon = 1'b0;
  logic tal_active = 1'b0, src_ready = 1'b0, talk_addressed = 1'b0, atn = 1'b0;
  logic no_byte_avail = 1'b0, dac_line = 1'b0, rfd_line = 1'b0;
  logic lis_active = 1'b0, listen_addressed = 1'b0, byte_accepted = 1'b0, eoi = 1'b0;
  logic [7:0] rx_byte = '0, eos_char = EOS;
  logic get_cmd = 1'b0, dcas_active = 1'b0;
  logic cpu_rd_din = 1'b0, cpu_wr_dout = 1'b0, cpu_rd_stat = 1'b0, cpu_wr_ien = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [5:0] stat;
  logic irq, dreq, trig;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  xfer_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .pon(pon), .tal_active(tal_active),
    .src_ready(src_ready), .talk_addressed(talk_addressed), .atn(atn),
    .no_byte_avail(no_byte_avail), .dac_line(dac_line), .rfd_line(rfd_line),
    .lis_active(lis_active), .listen_addressed(listen_addressed),
    .byte_accepted(byte_accepted), .eoi(eoi), .rx_byte(rx_byte),
    .eos_char(eos_char), .get_cmd(get_cmd), .dcas_active(dcas_active),
    .cpu_rd_din(cpu_rd_din), .cpu_wr_dout(cpu_wr_dout),
    .cpu_rd_stat(cpu_rd_stat), .cpu_wr_ien(cpu_wr_ien), .cpu_wdata(cpu_wdata),
    .stat(stat), .irq(irq), .dreq(dreq), .trig(trig)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [15:0] c, input logic [7:0] rx);
    tal_active = c[0];  src_ready = c[1];  talk_addressed = c[2]; atn = c[3];
    byte_accepted = c[4]; lis_active = c[5]; eoi = c[6]; no_byte_avail = c[7];
    dac_line = c[8]; rfd_line = c[9]; get_cmd = c[10]; listen_addressed = c[11];
    dcas_active = c[12]; cpu_rd_din = c[13]; cpu_wr_dout = c[14]; cpu_rd_stat = c[15];
    rx_byte = rx;
  endtask

  task automatic step(input logic [15:0] c, input logic [7:0] rx);
    drive(c, rx);
    tick();
  endtask

  task automatic write_ien(input logic [7:0] v);
    drive(C_NONE, 8'h00);
    cpu_wr_ien = 1'b1; cpu_wdata = v;
    tick();
    cpu_wr_ien = 1'b0;
  endtask

  task automatic check(input string req, input logic [5:0] es, input logic ei,
                       input logic ed, input logic et);
    n_run++;
    if (stat !== es || irq !== ei || dreq !== ed || trig !== et) begin
      n_fail++;
      $display("FAIL %s: stat=%b irq=%b dreq=%b trig=%b expected stat=%b irq=%b dreq=%b trig=%b",
               req, stat, irq, dreq, trig, es, ei, ed, et);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 reset", 6'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", 6'b0, 1'b0, 1'b0, 1'b0);
    // R10: bits 5..0 interrupt enables, bit 6 DMA-in, bit 7 DMA-out
    write_ien(8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      step(v[32:17], v[16:9]);
      check($sformatf("R2..R12 table vector %0d", i), v[8:3], v[2], v[1], v[0]);
    end

    // R10 masking: only byte-in enabled, DMA off
    write_ien(8'h01);
    step(C_LIS|C_BACC|C_EOI, 8'h55);
    check("R10 enabled flag", 6'b001001, 1'b1, 1'b0, 1'b0);
    step(C_RDIN, 8'h00);
    check("R10 masked end flag", 6'b001000, 1'b0, 1'b0, 1'b0);
    write_ien(8'hFF);
    check("R10 enable raises irq", 6'b001000, 1'b1, 1'b0, 1'b0);
    step(C_RST, 8'h00);
    check("R5 clear end", 6'b0, 1'b0, 1'b0, 1'b0);

    // R5 / R11: pon clears byte-out but keeps the DMA request
    step(C_TAL|C_SRC|C_TADR, 8'h00);
    check("R2 set before pon", 6'b000010, 1'b1, 1'b1, 1'b0);
    drive(C_TADR, 8'h00); pon = 1'b1; tick();
    check("R5 pon clears, R11 dreq kept", 6'b0, 1'b0, 1'b1, 1'b0);
    drive(C_TADR|C_BACC, 8'h00); tick();
    check("R12 pon vs byte-in", 6'b000001, 1'b1, 1'b1, 1'b0);
    pon = 1'b0;

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 6'b0, 1'b0, 1'b0, 1'b0);
    drive(C_NONE, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 enables cleared", 6'b0, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule